// File: doc/BRIEF.md
# Four-Tap Decision Feedback Equalizer for QPSK

This block removes multipath echoes from a stream of complex QPSK symbols that have already been mixed to baseband and low-pass filtered. It applies four complex coefficients. The precursor tap weights the newest sample. The reference tap weights the sample one symbol older, which is the symbol being decided. Two feedback taps weight the last two hard decisions instead of received samples. The weighted sum is scaled, saturated and sliced into a quadrant decision. The next stage is a differential decoder, which needs only the two sign bits.

Each time the symbol strobe is high, the block takes one I/Q pair. One cycle later it presents the equalized soft values, the quadrant decision and a one-cycle valid pulse. When the adapt-enable input is high during a strobe, every coefficient moves by a sign-sign LMS step. The step is driven by the error between the soft output and the ideal constellation point. Adapt-enable is typically tied to a carrier-lock flag.

Top module: `qdfe_eq`

## Requirements
- R1: While `rst` is high, `out_valid`, `eq_i`, `eq_q`, `dec_i` and `dec_q` are zero. After reset the reference tap is 1.0, which is 2^COEF_FRAC in the coefficient LSB. All other taps are zero, and the decision history is (positive, positive).
- R2: `out_valid` is high exactly in the cycle after a cycle with `sym_valid` high, and low otherwise.
- R3: With coefficients at their reset values, the outputs after a strobe equal the I/Q pair accepted at the previous strobe. After reset that earlier pair is zero. The sample accepted at the current strobe only feeds the precursor tap.
- R4: Each decision bit is the sign bit of its saturated rail: 1 means negative, and 0 means zero or positive.
- R5: The two feedback taps use the last two decisions. Each decision rail is mapped to +AMP when its bit is 0 and to -AMP when it is 1, with AMP defaulting to 64.
- R6: The error is the soft output minus the decision mapped to ±AMP. Each complex coefficient c moves by -2^-STEP_SHIFT times the sign-sign estimate of (error × conj(data)). Error signs are -1, 0 or +1, and data signs are -1 or +1, with zero counting as +1. A zero error on both rails leaves the coefficients unchanged.
- R7: A strobe with `adapt_en` low leaves all coefficients unchanged.
- R8: The sum of the four complex products is shifted right arithmetically by COEF_FRAC, which rounds toward minus infinity. It is then saturated to the signed DATA_W range, -128..127 by default.
- R9: With `sym_valid` low, the outputs and the internal sample and decision history stay unchanged, whatever appears on `in_i`, `in_q` and `adapt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol strobe; `in_i`/`in_q` are taken in this cycle |
| adapt_en | input | 1 | Enables coefficient adaptation on this strobe |
| in_i | input | DATA_W | In-phase sample, signed two's complement |
| in_q | input | DATA_W | Quadrature sample, signed two's complement |
| out_valid | output | 1 | One-cycle pulse marking new outputs |
| eq_i | output | DATA_W | Equalized in-phase soft value, saturated |
| eq_q | output | DATA_W | Equalized quadrature soft value, saturated |
| dec_i | output | 1 | In-phase decision, 1 = negative |
| dec_q | output | 1 | Quadrature decision, 1 = negative |

## Verification
Several properties are checked on every cycle:
- the shape of the valid pulse;
- outputs holding between strobes;
- agreement of the decisions with the soft-value signs;
- frozen coefficients when adaptation is off or the error is zero;
- the coefficient reset values.

The arithmetic can only be shown through bench scenarios with hand-computed results:
- the one-symbol delay through the reference tap;
- the exact size and direction of an adaptation step;
- the effect of the feedback taps on later symbols;
- saturation at both rails after adaptation has raised the gain.

// File: rtl/qdfe_pkg.sv
package qdfe_pkg;

    localparam int DEF_DATA_W     = 8;
    localparam int DEF_COEF_W     = 12;
    localparam int DEF_COEF_FRAC  = 10;
    localparam int DEF_STEP_SHIFT = 6;
    localparam int DEF_AMP        = 64;
    localparam int NTAPS          = 4;

    // Tap slots; the index order fixes which data each coefficient sees.
    typedef enum logic [1:0] {
        TAP_PRE = 2'd0,
        TAP_REF = 2'd1,
        TAP_FB1 = 2'd2,
        TAP_FB2 = 2'd3
    } tap_e;

    // Quadrant decision: one sign flag per rail, 1 = negative.
    typedef struct packed {
        logic neg_i;
        logic neg_q;
    } qdec_t;

    // Sign of a data value, zero counted as positive.
    function automatic logic signed [1:0] data_sign(input logic neg);
        return neg ? -2'sd1 : 2'sd1;
    endfunction

    // Three-valued sign of an error value.
    function automatic logic signed [1:0] err_sign(input logic neg, input logic zero);
        if (zero) return 2'sd0;
        return neg ? -2'sd1 : 2'sd1;
    endfunction

endpackage

// File: rtl/qdfe_tap.sv
module qdfe_tap
    import qdfe_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int COEF_W     = DEF_COEF_W,
    parameter int COEF_FRAC  = DEF_COEF_FRAC,
    parameter int STEP_SHIFT = DEF_STEP_SHIFT,
    parameter int INIT_RE    = 0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             upd,
    input  logic signed [DATA_W-1:0]         d_re,
    input  logic signed [DATA_W-1:0]         d_im,
    input  logic signed [1:0]                e_sgn_re,
    input  logic signed [1:0]                e_sgn_im,
    output logic signed [DATA_W+COEF_W:0]    p_re,
    output logic signed [DATA_W+COEF_W:0]    p_im
);
    localparam int PW = DATA_W + COEF_W;
    localparam int CW = COEF_W + 4;
    localparam logic signed [CW-1:0] STEP_L = CW'(1 << (COEF_FRAC - STEP_SHIFT));
    localparam logic signed [CW-1:0] CMAX   = CW'((1 << (COEF_W - 1)) - 1);
    localparam logic signed [CW-1:0] CMIN   = -CMAX - CW'(1);

    logic signed [COEF_W-1:0] c_re, c_im;
    logic signed [PW-1:0]     rr, ii, ri, ir;
    logic signed [1:0]        sx_re, sx_im;
    logic signed [2:0]        t_re, t_im;
    logic signed [CW-1:0]     nx_re, nx_im;
    logic signed [COEF_W-1:0] sat_re, sat_im;

    // Complex multiply c * d at full precision.
    always_comb begin
        rr   = PW'(c_re) * PW'(d_re);
        ii   = PW'(c_im) * PW'(d_im);
        ri   = PW'(c_re) * PW'(d_im);
        ir   = PW'(c_im) * PW'(d_re);
        p_re = (PW+1)'(rr) - (PW+1)'(ii);
        p_im = (PW+1)'(ri) + (PW+1)'(ir);
    end

    // Sign-sign estimate of e * conj(d); the coefficient moves against it.
    always_comb begin
        sx_re  = data_sign(d_re[DATA_W-1]);
        sx_im  = data_sign(d_im[DATA_W-1]);
        t_re   = 3'(e_sgn_re * sx_re) + 3'(e_sgn_im * sx_im);
        t_im   = 3'(e_sgn_im * sx_re) - 3'(e_sgn_re * sx_im);
        nx_re  = CW'(c_re) - CW'(t_re) * STEP_L;
        nx_im  = CW'(c_im) - CW'(t_im) * STEP_L;
        sat_re = (nx_re > CMAX) ? COEF_W'(CMAX) : (nx_re < CMIN) ? COEF_W'(CMIN) : COEF_W'(nx_re);
        sat_im = (nx_im > CMAX) ? COEF_W'(CMAX) : (nx_im < CMIN) ? COEF_W'(CMIN) : COEF_W'(nx_im);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_re <= COEF_W'(INIT_RE);
            c_im <= '0;
        end else if (upd) begin
            c_re <= sat_re;
            c_im <= sat_im;
        end
    end

    // R1: reset loads the tap's initial value
    p_init_r1: assert property (@(posedge clk)
        rst |=> (c_re == COEF_W'(INIT_RE) && c_im == '0));

    // R7: no update strobe, no coefficient change
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(c_re) && $stable(c_im)));

    // R6: zero error on both rails gives a zero step
    p_zero_err_r6: assert property (@(posedge clk) disable iff (rst)
        (upd && e_sgn_re == 2'sd0 && e_sgn_im == 2'sd0) |=> ($stable(c_re) && $stable(c_im)));

endmodule

// File: rtl/qdfe_slice.sv
module qdfe_slice
    import qdfe_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int COEF_FRAC = DEF_COEF_FRAC,
    parameter int AMP       = DEF_AMP,
    parameter int NT        = NTAPS
) (
    input  logic signed [DATA_W+COEF_W:0] p_re [NT],
    input  logic signed [DATA_W+COEF_W:0] p_im [NT],
    output logic signed [DATA_W-1:0]      y_re,
    output logic signed [DATA_W-1:0]      y_im,
    output qdec_t                         dec,
    output logic signed [1:0]             es_re,
    output logic signed [1:0]             es_im
);
    localparam int ACC_W = DATA_W + COEF_W + 1 + $clog2(NT);
    localparam int EW    = DATA_W + 2;
    localparam logic signed [ACC_W-1:0] YMAX = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] YMIN = -YMAX - ACC_W'(1);
    localparam logic signed [EW-1:0]    AMPW = EW'(AMP);

    logic signed [ACC_W-1:0] acc_re, acc_im, sh_re, sh_im;
    logic signed [EW-1:0]    e_re, e_im;

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int k = 0; k < NT; k++) begin
            acc_re = acc_re + ACC_W'(p_re[k]);
            acc_im = acc_im + ACC_W'(p_im[k]);
        end
        sh_re = acc_re >>> COEF_FRAC;
        sh_im = acc_im >>> COEF_FRAC;
        y_re  = (sh_re > YMAX) ? DATA_W'(YMAX) : (sh_re < YMIN) ? DATA_W'(YMIN) : DATA_W'(sh_re);
        y_im  = (sh_im > YMAX) ? DATA_W'(YMAX) : (sh_im < YMIN) ? DATA_W'(YMIN) : DATA_W'(sh_im);
    end

    // Quadrant slicer and decision error.
    always_comb begin
        dec.neg_i = y_re[DATA_W-1];
        dec.neg_q = y_im[DATA_W-1];
        e_re  = EW'(y_re) + (dec.neg_i ? AMPW : -AMPW);
        e_im  = EW'(y_im) + (dec.neg_q ? AMPW : -AMPW);
        es_re = err_sign(e_re[EW-1], e_re == '0);
        es_im = err_sign(e_im[EW-1], e_im == '0);
    end

endmodule

// File: rtl/qdfe_eq.sv
module qdfe_eq
    import qdfe_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int COEF_W     = DEF_COEF_W,
    parameter int COEF_FRAC  = DEF_COEF_FRAC,
    parameter int STEP_SHIFT = DEF_STEP_SHIFT,
    parameter int AMP        = DEF_AMP
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sym_valid,
    input  logic                     adapt_en,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] eq_i,
    output logic signed [DATA_W-1:0] eq_q,
    output logic                     dec_i,
    output logic                     dec_q
);
    localparam int PW  = DATA_W + COEF_W;
    localparam int ONE = 1 << COEF_FRAC;
    localparam logic signed [DATA_W-1:0] AMP_D = DATA_W'(AMP);

    logic signed [DATA_W-1:0] ref_i, ref_q;
    qdec_t                    hist1, hist2, dec_now;
    logic signed [DATA_W-1:0] td_re [NTAPS];
    logic signed [DATA_W-1:0] td_im [NTAPS];
    logic signed [PW:0]       tp_re [NTAPS];
    logic signed [PW:0]       tp_im [NTAPS];
    logic signed [DATA_W-1:0] y_re, y_im;
    logic signed [1:0]        es_re, es_im;
    logic                     upd;

    assign upd = sym_valid & adapt_en;

    // Data routed to each tap slot.
    always_comb begin
        td_re[int'(TAP_PRE)] = in_i;
        td_im[int'(TAP_PRE)] = in_q;
        td_re[int'(TAP_REF)] = ref_i;
        td_im[int'(TAP_REF)] = ref_q;
        td_re[int'(TAP_FB1)] = hist1.neg_i ? -AMP_D : AMP_D;
        td_im[int'(TAP_FB1)] = hist1.neg_q ? -AMP_D : AMP_D;
        td_re[int'(TAP_FB2)] = hist2.neg_i ? -AMP_D : AMP_D;
        td_im[int'(TAP_FB2)] = hist2.neg_q ? -AMP_D : AMP_D;
    end

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        qdfe_tap #(
            .DATA_W    (DATA_W),
            .COEF_W    (COEF_W),
            .COEF_FRAC (COEF_FRAC),
            .STEP_SHIFT(STEP_SHIFT),
            .INIT_RE   ((g == int'(TAP_REF)) ? ONE : 0)
        ) u_tap (
            .clk     (clk),
            .rst     (rst),
            .upd     (upd),
            .d_re    (td_re[g]),
            .d_im    (td_im[g]),
            .e_sgn_re(es_re),
            .e_sgn_im(es_im),
            .p_re    (tp_re[g]),
            .p_im    (tp_im[g])
        );
    end

    qdfe_slice #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC),
        .AMP      (AMP),
        .NT       (NTAPS)
    ) u_slice (
        .p_re (tp_re),
        .p_im (tp_im),
        .y_re (y_re),
        .y_im (y_im),
        .dec  (dec_now),
        .es_re(es_re),
        .es_im(es_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_i     <= '0;
            ref_q     <= '0;
            hist1     <= '0;
            hist2     <= '0;
            out_valid <= 1'b0;
            eq_i      <= '0;
            eq_q      <= '0;
            dec_i     <= 1'b0;
            dec_q     <= 1'b0;
        end else begin
            out_valid <= sym_valid;
            if (sym_valid) begin
                ref_i <= in_i;
                ref_q <= in_q;
                hist2 <= hist1;
                hist1 <= dec_now;
                eq_i  <= y_re;
                eq_q  <= y_im;
                dec_i <= dec_now.neg_i;
                dec_q <= dec_now.neg_q;
            end
        end
    end

    // R2: valid pulse follows each strobe by one cycle
    p_valid_r2: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> out_valid);
    p_novalid_r2: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !out_valid);

    // R9: outputs hold without a strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(eq_i) && $stable(eq_q) && $stable(dec_i) && $stable(dec_q)));

    // R4: decisions agree with the soft-value signs
    p_dec_sign_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dec_i == eq_i[DATA_W-1] && dec_q == eq_q[DATA_W-1]));

endmodule

// File: tb/sim_qdfe_eq.sv
module sim_qdfe_eq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic       adapt_en = 1'b0;
    logic [7:0] in_i = '0;
    logic [7:0] in_q = '0;
    logic       out_valid;
    logic [7:0] eq_i, eq_q;
    logic       dec_i, dec_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    qdfe_eq u0 (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .adapt_en(adapt_en),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
        .eq_i(eq_i), .eq_q(eq_q), .dec_i(dec_i), .dec_q(dec_q)
    );

    // {in_i, in_q, expected eq_i, expected eq_q}, coefficients at reset values
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        32'h0AEC_0000, 32'h0000_0AEC, 32'h7F80_0000, 32'hFF01_7F80,
        32'h807F_FF01, 32'h0500_807F, 32'h0000_0500
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] si, input logic [7:0] sq, input logic ad);
        @(negedge clk);
        in_i = si; in_q = sq; adapt_en = ad; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0; adapt_en = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int ei, input int eq);
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " eq_i"}, int'($signed(eq_i)), ei);
        chk({tag, " eq_q"}, int'($signed(eq_q)), eq);
        chk({tag, " dec_i"}, int'(dec_i), (ei < 0) ? 1 : 0);
        chk({tag, " dec_q"}, int'(dec_q), (eq < 0) ? 1 : 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 eq_i", int'(eq_i), 0);
        chk("R1 eq_q", int'(eq_q), 0);
        chk("R1 dec", int'({dec_i, dec_q}), 0);
        rst = 1'b0;

        // R3/R4/R8 table walk, adaptation off (R7: unity reference stays put)
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][31:24], VEC[v][23:16], 1'b0);
            expect_out($sformatf("R3 vec%0d", v),
                       int'($signed(VEC[v][15:8])), int'($signed(VEC[v][7:0])));
            // R9/R2: no strobe, garbage on inputs, nothing moves
            in_i = 8'h55; in_q = 8'hAA; adapt_en = 1'b1;
            @(negedge clk);
            chk("R2 pulse low", int'(out_valid), 0);
            @(negedge clk);
            adapt_en = 1'b0;
            chk("R9 hold i", int'($signed(eq_i)), int'($signed(VEC[v][15:8])));
            chk("R9 hold q", int'($signed(eq_q)), int'($signed(VEC[v][7:0])));
        end

        // R6/R5/R8: one adaptation step, then probes with adaptation off
        do_reset();
        send(8'h0A, 8'hEC, 1'b1);
        expect_out("R6 adapt step", 0, 0);
        send(8'h00, 8'h00, 1'b0);
        expect_out("R6 R5 probe1", 14, -17);
        send(8'h7F, 8'h80, 1'b0);
        expect_out("R5 probe2", 8, 3);
        send(8'h00, 8'h00, 1'b0);
        expect_out("R8 saturate", 127, -128);

        // R6: zero error leaves taps unchanged
        do_reset();
        send(8'h40, 8'hC0, 1'b0);
        expect_out("R6 zero prep", 0, 0);
        send(8'h00, 8'h00, 1'b1);
        expect_out("R6 zero err out", 64, -64);
        send(8'h00, 8'h00, 1'b0);
        expect_out("R6 zero err taps", 0, 0);

        // R1: reset mid-stream clears outputs
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again", int'({out_valid, eq_i, eq_q, dec_i, dec_q}), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule